// File: doc/BRIEF.md
# Pushbutton Contact-Bounce Filter

This block cleans the signal from a single-contact, normally open pushbutton. The raw contact level first passes through a two-flop synchronizer. A free-running prescaler then produces a one-cycle sample strobe. On each strobe, a short serial shift register compares its serial input, which is the synchronized contact level, with its serial output, which is the debounced level. When the two levels disagree, the register shifts the new level in by one stage. When they agree, every stage is reloaded with the output level.

As a result, a level change reaches the output only after it has been sampled on a full register length of consecutive strobes. Any shorter bounce or glitch is wiped out by the next agreeing sample. Press and release are filtered in the same way. The whole block runs on the system clock, and the strobe acts as a clock enable.

The register has three actions per clock, all set by a decode in the package: `ACT_HOLD`, `ACT_SHIFT` and `ACT_RELOAD`. The transitions are:
- no strobe leads to `ACT_HOLD`;
- a strobe with disagreeing levels leads to `ACT_SHIFT`;
- a strobe with agreeing levels leads to `ACT_RELOAD`.

Top module: `pb_debounce`

## Requirements
- R1: While `rst_n` is low, and afterwards until a press has been qualified, `btn_clean` is 0 (released).
- R2: `btn_raw` reaches the sampler through exactly two clock flops. The first flop holds the value of `btn_raw` from the previous edge.
- R3: The sample strobe fires once every 2^PRESCALE_BITS clocks. The first strobe is on the 2^PRESCALE_BITS-th rising edge after reset is released. The register does not change on edges without a strobe.
- R4: On a strobe where the synchronized level differs from `btn_clean` (`ACT_SHIFT`), the synchronized level enters stage 0 and every other stage takes the value of the stage below it.
- R5: On a strobe where the synchronized level equals `btn_clean` (`ACT_RELOAD`), all stages take the value of `btn_clean`. A differing level that lasts fewer than STAGES consecutive strobes therefore never changes the output.
- R6: `btn_clean` is the last stage of the register. It changes only on an edge that carries a strobe, and it takes the synchronized level only after STAGES (default 4) consecutive strobes that sampled that level.
- R7: A settled transition, including one preceded by a burst of bounce, changes `btn_clean` exactly once. Press (0 to 1) and release (1 to 0) behave the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Raw contact level, asynchronous, 1 = pressed |
| btn_clean | output | 1 | Debounced level, 1 = pressed |

## Verification
On one edge, the sample strobe and a new level leaving the synchronizer can coincide. The comparison then sees the fresh level, and whether that strobe shifts or reloads decides when the output moves. The bench provokes this by starting each pulse and bounce burst at every phase of the prescaler period. The prescaler is reduced to eight clocks. The output is compared on every cycle against an arithmetic model of the requirements, and in addition the number of output changes is counted for pulses that are clearly too short and clearly long enough.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    // Per-clock action of the filter register
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SHIFT  = 2'd1,
        ACT_RELOAD = 2'd2
    } act_e;

    function automatic act_e decode_act(input logic strobe, input logic same);
        act_e a;
        unique case ({strobe, same})
            2'b10:   a = ACT_SHIFT;
            2'b11:   a = ACT_RELOAD;
            default: a = ACT_HOLD;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dbnc_prescaler.sv
module dbnc_prescaler #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign strobe = &cnt_q;

    // R3: strobe never on two edges in a row
    p_strobe_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] chain_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b0;
                else        chain_q[i] <= (i == 0) ? din : chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain_q[DEPTH-1];

    // R2: first flop holds the previous edge's input
    p_first_flop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> chain_q[0] == $past(din));

endmodule

// File: rtl/dbnc_shreg.sv
module dbnc_shreg
    import dbnc_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic ser_in,
    output logic ser_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stage_q;
    logic          same;
    act_e          act;

    assign ser_out = stage_q[LAST];
    assign same    = ~(ser_in ^ ser_out);

    always_comb act = decode_act(strobe, same);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            unique case (act)
                ACT_SHIFT:  stage_q <= {stage_q[LAST-1:0], ser_in};
                ACT_RELOAD: stage_q <= {STAGES{ser_out}};
                default:    stage_q <= stage_q;
            endcase
        end
    end

    // R3: no change without a strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(stage_q));

    // R4: shift moves input into stage 0 and advances the rest
    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (ser_in != ser_out)) |=>
            (stage_q[0] == $past(ser_in)) && (stage_q[LAST:1] == $past(stage_q[LAST-1:0])));

    // R5: agreement makes every stage equal the previous output
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (ser_in == ser_out)) |=> (stage_q == {STAGES{$past(ser_out)}}));

endmodule

// File: rtl/pb_debounce.sv
module pb_debounce #(
    parameter int STAGES        = 4,
    parameter int PRESCALE_BITS = 16,
    parameter int SYNC_DEPTH    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic btn_clean
);
    logic strobe;
    logic sync_lvl;

    dbnc_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (btn_raw),
        .dout  (sync_lvl)
    );

    dbnc_prescaler #(.WIDTH(PRESCALE_BITS)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    dbnc_shreg #(.STAGES(STAGES)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .ser_in  (sync_lvl),
        .ser_out (btn_clean)
    );

    // R6: output moves only on a strobe edge
    p_out_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(btn_clean) |-> $past(strobe));

    // R6: a new output value is the synchronized level that was sampled
    p_out_from_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(btn_clean) |-> (btn_clean == $past(sync_lvl)));

endmodule

// File: tb/pb_debounce_tb.sv
`timescale 1ns/1ps
module pb_debounce_tb;
    localparam int STAGES = 4;
    localparam int PBITS  = 3;
    localparam int PER    = 1 << PBITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_raw = 1'b0;
    logic btn_clean;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    logic prev_out = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pb_debounce #(.STAGES(STAGES), .PRESCALE_BITS(PBITS), .SYNC_DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .btn_clean(btn_clean)
    );

    // Arithmetic reference built from R2, R3, R5, R6
    logic m_s1, m_s2, m_out;
    int   m_cyc, m_run;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_out <= 0; m_cyc <= 0; m_run <= 0;
        end else begin
            m_s1  <= btn_raw;
            m_s2  <= m_s1;
            m_cyc <= (m_cyc == PER-1) ? 0 : m_cyc + 1;
            if (m_cyc == PER-1) begin
                if (m_s2 != m_out) begin
                    if (m_run + 1 == STAGES) begin
                        m_out <= m_s2; m_run <= 0;
                    end else m_run <= m_run + 1;
                end else m_run <= 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(btn_clean === m_out, "R2 R3 R4 R6 cycle model", btn_clean, m_out);
            if (btn_clean !== prev_out) edges++;
            prev_out = btn_clean;
        end
    end

    task automatic drive(input logic v, input int n);
        btn_raw = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic cur;
        repeat (3) @(negedge clk);
        check(btn_clean === 1'b0, "R1 in reset", btn_clean, 0);
        rst_n = 1'b1;
        drive(1'b0, 20);
        check(btn_clean === 1'b0, "R1 after reset", btn_clean, 0);
        cur = 1'b0;
        for (int lvl = 0; lvl < 2; lvl++) begin
            drive(lvl[0], 80);
            cur = lvl[0];
            check(btn_clean === cur, "R7 settle level", btn_clean, cur);
            for (int ph = 0; ph < PER; ph++) begin
                for (int len = 1; len <= 6; len++) begin
                    drive(cur, ph + 1);
                    edges = 0;
                    drive(~cur, len * PER);
                    drive(cur, 80);
                    if (len <= 2)
                        check(edges == 0, "R5 short pulse ignored", edges, 0);
                    else if (len == 6)
                        check(edges == 2, "R6 long pulse passes and returns", edges, 2);
                    check(btn_clean === cur, "R5 level restored", btn_clean, cur);
                end
                // bounce bursts on both directions
                drive(cur, ph + 1);
                edges = 0;
                for (int b = 0; b < 10; b++) begin
                    drive(~cur, 1);
                    drive(cur, 1);
                end
                drive(~cur, 80);
                check(edges == 1, "R7 bounce then settle flips once", edges, 1);
                check(btn_clean === ~cur, "R7 settled level", btn_clean, ~cur);
                for (int b = 0; b < 10; b++) begin
                    drive(cur, 1 + (b % 2));
                    drive(~cur, 1);
                end
                drive(cur, 80);
                check(edges == 2, "R7 bounce back flips once", edges, 2);
                check(btn_clean === cur, "R7 back level", btn_clean, cur);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule